// File: doc/BRIEF.md
# Identity Register Loader for a Bus Target

This block fills the read-only identity fields of a PCI-style target after reset. These fields are device and vendor numbers, class code, revision, header type, subsystem numbers, latency and grant hints, and the interrupt pin. A static strap input picks the source of the values. With the strap low, an on-chip controller writes eight 16-bit words over a local bus, and a counter steers each word to its fields in a fixed sequence. With the strap high, hardwired default values are applied on the first clock after reset is released.

Until every field is filled, the block keeps the host side mute. No request of any kind is claimed, configuration accesses included. After that, configuration requests are claimed. Memory requests are claimed only once the host has written both the memory base-address register and the command register. I/O requests are never claimed, because only memory space is decoded. The PCI protocol engine sits outside this block. It reports register writes and incoming request types, and it uses the registered claim output.

Top module: `ident_cfg_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the following are cleared: the ready flag, the word counter, both host-write-seen flags, `tgt_mem_en`, `host_claim` and every identity field output.
- R2: With `strap_idle` low and not ready, each cycle with `ld_we` high stores `ld_data` as the next word, and the result is visible the cycle after. The words are mapped in arrival order as follows:
  - word 0 = {max_lat, min_gnt}
  - word 1 = {class_code[23:16], hdr_type}
  - word 2 = class_code[15:0]
  - word 3 = {int_pin, rev_id}
  - word 4 = ssys_id
  - word 5 = ssys_ven_id
  - word 6 = dev_id
  - word 7 = ven_id
- R3: `ident_ready` rises in the cycle after the eighth word is written. It then stays high until reset.
- R4: Load writes have no effect on the field outputs once ready. They also have no effect at any time while `strap_idle` is high.
- R5: With `strap_idle` high, `ident_ready` is high one clock after reset is released. The fields then read as follows:
  - dev_id 0x3873
  - ven_id 0x1260
  - class_code 0x028000
  - ssys_id 0x0000
  - ssys_ven_id 0x1260
  - rev_id 0x01
  - hdr_type 0x00
  - max_lat 0x00
  - min_gnt 0x00
  - int_pin 0x01
- R6: While not ready, `host_claim` stays low for every request kind.
- R7: A request that is valid with kind 2'b00 (configuration) at an edge where the block is ready raises `host_claim` in the next cycle.
- R8: A request of kind 2'b01 (memory) is claimed only if `tgt_mem_en` was high at that edge. `tgt_mem_en` rises the cycle after both a base-address write and a command write have been seen. The two writes may come in either order or in the same cycle.
- R9: Request kinds 2'b10 (I/O) and 2'b11 (reserved) are never claimed.
- R10: Base-address and command writes made while not ready are not recorded.
- R11: Once ready, the identity field outputs do not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_idle | input | 1 | Static strap: 1 selects default values, 0 selects controller loading |
| ld_we | input | 1 | Local-bus word write strobe |
| ld_data | input | 16 | Local-bus word |
| host_bar_wr | input | 1 | Host wrote the memory base-address register |
| host_cmd_wr | input | 1 | Host wrote the command register |
| host_req_valid | input | 1 | A host request is presented this cycle |
| host_req_kind | input | 2 | Request type: 0 config, 1 memory, 2 I/O, 3 reserved |
| ident_ready | output | 1 | All identity fields filled |
| tgt_mem_en | output | 1 | Memory target operation enabled |
| host_claim | output | 1 | Registered claim of the previous cycle's request |
| dev_id | output | 16 | Device number |
| ven_id | output | 16 | Vendor number |
| class_code | output | 24 | Class code |
| rev_id | output | 8 | Revision |
| hdr_type | output | 8 | Header type |
| ssys_id | output | 16 | Subsystem number |
| ssys_ven_id | output | 16 | Subsystem vendor number |
| max_lat | output | 8 | Maximum latency hint |
| min_gnt | output | 8 | Minimum grant hint |
| int_pin | output | 8 | Interrupt pin |

## Verification
The bench sends configuration and memory requests before loading finishes. A design that answers early would claim them. It writes past the eighth word and strobes the load bus in default mode. A counter that fails to stop, or a default path that lets the bus through, would corrupt fields that should be frozen. It writes the base-address register before ready and the command register after. A gate that records early writes would enable memory claims too soon. It also delivers both host writes in one cycle, reversed relative to the run-mode test, and presents I/O and reserved requests that must never be claimed.

// File: rtl/idl_pkg.sv
package idl_pkg;
  typedef enum logic [1:0] {
    REQ_CFG = 2'b00,
    REQ_MEM = 2'b01,
    REQ_IO  = 2'b10,
    REQ_RSV = 2'b11
  } req_kind_e;
endpackage

// File: rtl/idl_load_seq.sv
module idl_load_seq #(
  parameter int N_WORDS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strap_idle,
  input  logic               ld_we,
  output logic [N_WORDS-1:0] word_we,
  output logic               dflt_load,
  output logic               ready
);
  localparam int CNT_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [CNT_W-1:0] cnt;
  logic             run_we;
  logic             last_word;

  assign run_we    = ld_we && !ready && !strap_idle;
  assign dflt_load = !ready && strap_idle;
  assign last_word = (cnt == CNT_W'(N_WORDS - 1));

  genvar gi;
  generate
    for (gi = 0; gi < N_WORDS; gi++) begin : g_sel
      assign word_we[gi] = run_we && (cnt == CNT_W'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (run_we && !last_word) cnt <= cnt + 1'b1;
      if (dflt_load || (run_we && last_word)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/idl_word_bank.sv
module idl_word_bank #(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_WORDS-1:0]        word_we,
  input  logic                      dflt_load,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [N_WORDS*WORD_W-1:0] dflt_flat,
  output logic [N_WORDS*WORD_W-1:0] words_flat
);
  genvar gi;
  generate
    for (gi = 0; gi < N_WORDS; gi++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst)
          word_q <= '0;
        else if (dflt_load)
          word_q <= dflt_flat[gi*WORD_W +: WORD_W];
        else if (word_we[gi])
          word_q <= wr_data;
      end
      assign words_flat[gi*WORD_W +: WORD_W] = word_q;
    end
  endgenerate
endmodule

// File: rtl/idl_host_gate.sv
module idl_host_gate
  import idl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ready,
  input  logic       bar_wr,
  input  logic       cmd_wr,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  output logic       tgt_mem_en,
  output logic       claim
);
  logic bar_seen, cmd_seen;
  logic bar_nxt, cmd_nxt;
  logic want;

  assign bar_nxt = bar_seen || (ready && bar_wr);
  assign cmd_nxt = cmd_seen || (ready && cmd_wr);

  always_comb begin
    want = 1'b0;
    if (req_valid && ready) begin
      unique case (req_kind_e'(req_kind))
        REQ_CFG: want = 1'b1;
        REQ_MEM: want = tgt_mem_en;
        REQ_IO:  want = 1'b0;
        REQ_RSV: want = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_seen   <= 1'b0;
      cmd_seen   <= 1'b0;
      tgt_mem_en <= 1'b0;
      claim      <= 1'b0;
    end else begin
      bar_seen   <= bar_nxt;
      cmd_seen   <= cmd_nxt;
      tgt_mem_en <= bar_nxt && cmd_nxt;
      claim      <= want;
    end
  end
endmodule

// File: rtl/ident_cfg_loader.sv
module ident_cfg_loader #(
  parameter logic [15:0] DFLT_DEV_ID   = 16'h3873,
  parameter logic [15:0] DFLT_VEN_ID   = 16'h1260,
  parameter logic [23:0] DFLT_CLASS    = 24'h028000,
  parameter logic [15:0] DFLT_SSYS_ID  = 16'h0000,
  parameter logic [15:0] DFLT_SSYS_VEN = 16'h1260,
  parameter logic [7:0]  DFLT_REV      = 8'h01,
  parameter logic [7:0]  DFLT_HDR      = 8'h00,
  parameter logic [7:0]  DFLT_MAX_LAT  = 8'h00,
  parameter logic [7:0]  DFLT_MIN_GNT  = 8'h00,
  parameter logic [7:0]  DFLT_INT_PIN  = 8'h01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        strap_idle,
  input  logic        ld_we,
  input  logic [15:0] ld_data,
  input  logic        host_bar_wr,
  input  logic        host_cmd_wr,
  input  logic        host_req_valid,
  input  logic [1:0]  host_req_kind,
  output logic        ident_ready,
  output logic        tgt_mem_en,
  output logic        host_claim,
  output logic [15:0] dev_id,
  output logic [15:0] ven_id,
  output logic [23:0] class_code,
  output logic [7:0]  rev_id,
  output logic [7:0]  hdr_type,
  output logic [15:0] ssys_id,
  output logic [15:0] ssys_ven_id,
  output logic [7:0]  max_lat,
  output logic [7:0]  min_gnt,
  output logic [7:0]  int_pin
);
  localparam int N_WORDS = 8;
  localparam int WORD_W  = 16;
  localparam int FLAT_W  = N_WORDS * WORD_W;

  logic [N_WORDS-1:0] word_we;
  logic               dflt_load;
  logic [FLAT_W-1:0]  dflt_flat;
  logic [FLAT_W-1:0]  words_flat;
  logic [WORD_W-1:0]  w [N_WORDS];

  assign dflt_flat = {DFLT_VEN_ID, DFLT_DEV_ID, DFLT_SSYS_VEN, DFLT_SSYS_ID,
                      DFLT_INT_PIN, DFLT_REV, DFLT_CLASS[15:0],
                      DFLT_CLASS[23:16], DFLT_HDR, DFLT_MAX_LAT, DFLT_MIN_GNT};

  idl_load_seq #(.N_WORDS(N_WORDS)) u_seq (
    .clk(clk), .rst(rst), .strap_idle(strap_idle), .ld_we(ld_we),
    .word_we(word_we), .dflt_load(dflt_load), .ready(ident_ready)
  );

  idl_word_bank #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst(rst), .word_we(word_we), .dflt_load(dflt_load),
    .wr_data(ld_data), .dflt_flat(dflt_flat), .words_flat(words_flat)
  );

  idl_host_gate u_gate (
    .clk(clk), .rst(rst), .ready(ident_ready), .bar_wr(host_bar_wr),
    .cmd_wr(host_cmd_wr), .req_valid(host_req_valid), .req_kind(host_req_kind),
    .tgt_mem_en(tgt_mem_en), .claim(host_claim)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_WORDS; gi++) begin : g_unpack
      assign w[gi] = words_flat[gi*WORD_W +: WORD_W];
    end
  endgenerate

  assign max_lat     = w[0][15:8];
  assign min_gnt     = w[0][7:0];
  assign class_code  = {w[1][15:8], w[2]};
  assign hdr_type    = w[1][7:0];
  assign int_pin     = w[3][15:8];
  assign rev_id      = w[3][7:0];
  assign ssys_id     = w[4];
  assign ssys_ven_id = w[5];
  assign dev_id      = w[6];
  assign ven_id      = w[7];
endmodule

// File: rtl/ident_cfg_loader_chk.sv
module ident_cfg_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        strap_idle,
  input logic [1:0]  host_req_kind,
  input logic        ident_ready,
  input logic        tgt_mem_en,
  input logic        host_claim,
  input logic [15:0] dev_id,
  input logic [15:0] ven_id,
  input logic [23:0] class_code,
  input logic [7:0]  rev_id,
  input logic [7:0]  hdr_type,
  input logic [15:0] ssys_id,
  input logic [15:0] ssys_ven_id,
  input logic [7:0]  max_lat,
  input logic [7:0]  min_gnt,
  input logic [7:0]  int_pin
);
  logic [127:0] fields;
  assign fields = {dev_id, ven_id, class_code, rev_id, hdr_type, ssys_id,
                   ssys_ven_id, max_lat, min_gnt, int_pin};

  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ident_ready |=> ident_ready);

  p_dflt_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (strap_idle && !ident_ready) |=> (ident_ready && dev_id == 16'h3873 && ven_id == 16'h1260));

  p_no_early_claim_r6: assert property (@(posedge clk) disable iff (rst)
    host_claim |-> $past(ident_ready));

  p_mem_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    (host_claim && $past(host_req_kind) == 2'b01) |-> $past(tgt_mem_en));

  p_en_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
    tgt_mem_en |-> ident_ready);

  p_no_io_claim_r9: assert property (@(posedge clk) disable iff (rst)
    host_claim |-> ($past(host_req_kind) == 2'b00 || $past(host_req_kind) == 2'b01));

  p_frozen_fields_r11: assert property (@(posedge clk) disable iff (rst)
    (ident_ready && $past(ident_ready)) |-> $stable(fields));
endmodule

bind ident_cfg_loader ident_cfg_loader_chk u_chk (
  .clk(clk), .rst(rst), .strap_idle(strap_idle), .host_req_kind(host_req_kind),
  .ident_ready(ident_ready), .tgt_mem_en(tgt_mem_en), .host_claim(host_claim),
  .dev_id(dev_id), .ven_id(ven_id), .class_code(class_code), .rev_id(rev_id),
  .hdr_type(hdr_type), .ssys_id(ssys_id), .ssys_ven_id(ssys_ven_id),
  .max_lat(max_lat), .min_gnt(min_gnt), .int_pin(int_pin)
);

// File: tb/ident_cfg_loader_tb.sv
module ident_cfg_loader_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, strap_idle = 1'b0, ld_we = 1'b0;
  logic [15:0] ld_data = '0;
  logic        host_bar_wr = 1'b0, host_cmd_wr = 1'b0, host_req_valid = 1'b0;
  logic [1:0]  host_req_kind = 2'b00;
  logic        ident_ready, tgt_mem_en, host_claim;
  logic [15:0] dev_id, ven_id, ssys_id, ssys_ven_id;
  logic [23:0] class_code;
  logic [7:0]  rev_id, hdr_type, max_lat, min_gnt, int_pin;

  ident_cfg_loader u_dut (.*);

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";

  logic [15:0] m_q[$];
  bit m_rdy, m_bar, m_cmd, m_ten, m_clm;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete(); m_rdy = 0; m_bar = 0; m_cmd = 0; m_ten = 0; m_clm = 0;
    end else begin
      m_clm = host_req_valid && m_rdy &&
              (host_req_kind == 2'b00 || (host_req_kind == 2'b01 && m_ten));
      if (m_rdy) begin
        if (host_bar_wr) m_bar = 1;
        if (host_cmd_wr) m_cmd = 1;
        m_ten = m_bar && m_cmd;
      end
      if (!m_rdy) begin
        if (strap_idle) begin
          m_q = '{16'h0000, 16'h0200, 16'h8000, 16'h0101,
                  16'h0000, 16'h1260, 16'h3873, 16'h1260};
          m_rdy = 1;
        end else if (ld_we) begin
          m_q.push_back(ld_data);
          if (m_q.size() == 8) m_rdy = 1;
        end
      end
    end
  end

  function automatic logic [15:0] mw(int i);
    return (i < m_q.size()) ? m_q[i] : 16'h0000;
  endfunction

  task automatic cmp(string nm, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, nm, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp("ident_ready", 32'(ident_ready), 32'(m_rdy));
    cmp("tgt_mem_en", 32'(tgt_mem_en), 32'(m_ten));
    cmp("host_claim", 32'(host_claim), 32'(m_clm));
    cmp("max_lat/min_gnt", {16'h0, max_lat, min_gnt}, 32'(mw(0)));
    cmp("class_code", 32'(class_code), {8'h0, mw(1)[15:8], mw(2)});
    cmp("hdr_type", 32'(hdr_type), 32'(mw(1)[7:0]));
    cmp("int_pin/rev_id", {16'h0, int_pin, rev_id}, 32'(mw(3)));
    cmp("ssys_id", 32'(ssys_id), 32'(mw(4)));
    cmp("ssys_ven_id", 32'(ssys_ven_id), 32'(mw(5)));
    cmp("dev_id", 32'(dev_id), 32'(mw(6)));
    cmp("ven_id", 32'(ven_id), 32'(mw(7)));
    ld_we = 0; host_bar_wr = 0; host_cmd_wr = 0; host_req_valid = 0;
  endtask

  task automatic req(logic [1:0] k);
    host_req_valid = 1; host_req_kind = k; cyc();
  endtask

  task automatic ld(logic [15:0] d);
    ld_we = 1; ld_data = d; cyc();
  endtask

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) cyc();
    rst = 0;
    // R6: requests before ready; R10: early base-address write
    cur_req = "R6";
    req(2'b00); req(2'b01);
    cur_req = "R10";
    host_bar_wr = 1; cyc();
    // R2: run-mode load, with gaps
    cur_req = "R2";
    ld(16'hA1B2); cyc(); ld(16'h0C11); ld(16'h0330); cyc(); cyc();
    ld(16'h0105); ld(16'h4455); req(2'b00); ld(16'h6677); ld(16'h8899);
    cur_req = "R3";
    ld(16'hAABB);
    cmp("R3 ready after 8th", 32'(ident_ready), 32'd1);
    cmp("R2 max_lat", 32'(max_lat), 32'hA1);
    cmp("R2 class_code", 32'(class_code), 32'h0C0330);
    cmp("R2 ven_id", 32'(ven_id), 32'hAABB);
    // R4 / R11: writes after ready ignored
    cur_req = "R4";
    ld(16'hDEAD); ld(16'hBEEF);
    cur_req = "R11";
    cmp("R4 max_lat unchanged", 32'(max_lat), 32'hA1);
    // R7: config claim
    cur_req = "R7";
    req(2'b00);
    cmp("R7 claim", 32'(host_claim), 32'd1);
    // R10: only command write now; memory must not be claimed
    cur_req = "R10";
    host_cmd_wr = 1; cyc();
    req(2'b01);
    cmp("R10 no mem claim", 32'(host_claim), 32'd0);
    // R8: base-address write completes the pair
    cur_req = "R8";
    host_bar_wr = 1; cyc();
    cmp("R8 tgt_mem_en", 32'(tgt_mem_en), 32'd1);
    req(2'b01);
    cmp("R8 mem claim", 32'(host_claim), 32'd1);
    // R9: I/O and reserved
    cur_req = "R9";
    req(2'b10);
    cmp("R9 io", 32'(host_claim), 32'd0);
    req(2'b11); req(2'b01);
    // Reset mid-load, then default mode
    cur_req = "R1";
    rst = 1; cyc(); cyc(); rst = 0;
    ld(16'h1111); ld(16'h2222);
    rst = 1; strap_idle = 1; cyc();
    cmp("R1 cleared", 32'(ident_ready), 32'd0);
    rst = 0;
    cur_req = "R5";
    ld_we = 1; ld_data = 16'hFFFF; cyc();
    cmp("R5 ready", 32'(ident_ready), 32'd1);
    cmp("R5 dev_id", 32'(dev_id), 32'h3873);
    cmp("R5 class_code", 32'(class_code), 32'h028000);
    cmp("R5 int_pin", 32'(int_pin), 32'h01);
    cur_req = "R4";
    ld(16'h5A5A);
    cmp("R4 idle ignore", 32'(max_lat), 32'h00);
    cur_req = "R8";
    req(2'b01);
    host_bar_wr = 1; host_cmd_wr = 1; cyc();
    cmp("R8 same-cycle", 32'(tgt_mem_en), 32'd1);
    req(2'b01); req(2'b00); req(2'b10);
    repeat (3) cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule